// File: doc/BRIEF.md
# Two-Way Traffic Light Sequencer

This block controls the lamps of two crossing roads from one timing input. It steps around a ring of four phases. Road 1 green with road 2 red comes first. Road 1 then shows yellow while road 2 stays red. Next road 1 is red and road 2 is green. Last, road 1 stays red while road 2 shows yellow. There is no internal timer: an external timing generator drives `t_adv`. A green phase leaves when `t_adv` is sampled high. A yellow phase leaves when `t_adv` is sampled low. In every other case the phase holds. Each green therefore hands the right of way to the other road only after a yellow phase.

The phase register comes in two builds, chosen by a parameter. One build uses one flip-flop per phase. The other uses a two-bit sequence register with a two-to-four decoder. Both builds drive the same six lamp outputs and give the same cycle-by-cycle behaviour. Reset is asserted asynchronously and released through a synchronizer inside the block.

Top module: `tl_ring_ctrl`

## Requirements
- R1: While `rst_n` is low, the lamps show road 1 green and road 2 red, and this takes effect without waiting for a clock edge. After `rst_n` rises, the phase ignores `t_adv` for two rising edges. The first edge that can change the phase is the third one.
- R2: In the road 1 green phase, a rising edge with `t_adv` low keeps the lamps at road 1 green and road 2 red.
- R3: In the road 1 green phase, a rising edge with `t_adv` high moves the lamps to road 1 yellow and road 2 red, visible after that edge.
- R4: In the road 1 yellow phase, an edge with `t_adv` high holds the phase. An edge with `t_adv` low moves to road 1 red and road 2 green.
- R5: In the road 2 green phase, an edge with `t_adv` low holds the phase. An edge with `t_adv` high moves to road 1 red and road 2 yellow.
- R6: In the road 2 yellow phase, an edge with `t_adv` high holds the phase. An edge with `t_adv` low returns to road 1 green and road 2 red, which closes the ring.
- R7: In every cycle, exactly one of red, yellow and green is lit on each road. The two roads are never both showing a lamp other than red.
- R8: The one-flip-flop-per-phase build (`ONE_HOT`=1) and the encoded build (`ONE_HOT`=0) produce identical lamp outputs in every cycle for the same reset and `t_adv` stimulus. The encoded build uses codes 00, 01, 10 and 11 for the four phases in ring order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside the block |
| t_adv | input | 1 | Timing level: high ends a green phase, low ends a yellow phase |
| s1_red | output | 1 | Road 1 red lamp |
| s1_yel | output | 1 | Road 1 yellow lamp |
| s1_grn | output | 1 | Road 1 green lamp |
| s2_red | output | 1 | Road 2 red lamp |
| s2_yel | output | 1 | Road 2 yellow lamp |
| s2_grn | output | 1 | Road 2 green lamp |

## Verification
Each phase is first given a long run of the level that must not move it, then one edge of the opposite level. This separates a correct hold from a phase that advances on any edge or that reads the level with the wrong sense. Toggling `t_adv` every cycle forces one step per edge around several full laps, which shows that the ring closes and the order of the phases is right. Holds of uneven length show that a step depends only on the sampled level and not on a count. Holding `t_adv` high across reset release tells a correct synchronizer delay apart from an early or late first step. Asserting reset in the middle of a cycle shows that reset does not wait for the clock. Both builds run side by side, and any difference between their lamps in any cycle is reported.

// File: rtl/tl_ring_pkg.sv
package tl_ring_pkg;

  localparam int NUM_PHASES = 4;
  localparam int PHASE_W    = $clog2(NUM_PHASES);

  // Ring order; the encoded build steps through these codes by increment.
  typedef enum logic [PHASE_W-1:0] {
    PH_G1R2 = 2'b00,
    PH_Y1R2 = 2'b01,
    PH_R1G2 = 2'b10,
    PH_R1Y2 = 2'b11
  } phase_e;

  typedef struct packed {
    logic red;
    logic yel;
    logic grn;
  } lamp_t;

  // Odd ring positions are yellow phases: they leave on a low level.
  function automatic logic leaves_phase(input int unsigned pos, input logic lvl);
    return (pos % 2 == 1) ? ~lvl : lvl;
  endfunction

endpackage

// File: rtl/tl_rst_sync.sv
module tl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/tl_seq_enc.sv
module tl_seq_enc
  import tl_ring_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  t_adv,
  output logic [NUM_PHASES-1:0] phase_oh
);

  logic [PHASE_W-1:0] cur_q;
  logic [PHASE_W-1:0] nxt;
  logic               step_en;

  // Green codes (bit 0 clear) step on a high level, yellow codes on a low level.
  always_comb begin
    step_en = cur_q[0] ? ~t_adv : t_adv;
    nxt     = cur_q + PHASE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= PH_G1R2;
    end else if (step_en) begin
      cur_q <= nxt;
    end
  end

  // Decoder: one output line per code.
  for (genvar k = 0; k < NUM_PHASES; k++) begin : g_dec
    assign phase_oh[k] = (32'(cur_q) == k);
  end

endmodule

// File: rtl/tl_seq_onehot.sv
module tl_seq_onehot
  import tl_ring_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  t_adv,
  output logic [NUM_PHASES-1:0] phase_oh
);

  logic [NUM_PHASES-1:0] hot_q;
  logic [NUM_PHASES-1:0] leave;
  logic [NUM_PHASES-1:0] nxt_raw;
  logic [NUM_PHASES-1:0] nxt;
  logic                  upd_en;

  for (genvar i = 0; i < NUM_PHASES; i++) begin : g_ff
    localparam int PREV = (i + NUM_PHASES - 1) % NUM_PHASES;
    assign leave[i]   = hot_q[i] & leaves_phase(i, t_adv);
    assign nxt_raw[i] = (hot_q[i] & ~leave[i]) | leave[PREV];
  end

  // A corrupted token vector falls back to the first phase.
  always_comb begin
    if ($onehot(hot_q)) begin
      nxt = nxt_raw;
    end else begin
      nxt = NUM_PHASES'(1);
    end
    upd_en = (nxt != hot_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hot_q <= NUM_PHASES'(1);
    end else if (upd_en) begin
      hot_q <= nxt;
    end
  end

  assign phase_oh = hot_q;

endmodule

// File: rtl/tl_lamp_dec.sv
module tl_lamp_dec
  import tl_ring_pkg::*;
(
  input  logic [NUM_PHASES-1:0] phase_oh,
  output lamp_t                 road1,
  output lamp_t                 road2
);

  always_comb begin
    road1.grn = phase_oh[PH_G1R2];
    road1.yel = phase_oh[PH_Y1R2];
    road1.red = phase_oh[PH_R1G2] | phase_oh[PH_R1Y2];
    road2.grn = phase_oh[PH_R1G2];
    road2.yel = phase_oh[PH_R1Y2];
    road2.red = phase_oh[PH_G1R2] | phase_oh[PH_Y1R2];
  end

endmodule

// File: rtl/tl_ring_ctrl.sv
module tl_ring_ctrl
  import tl_ring_pkg::*;
#(
  parameter bit ONE_HOT    = 1'b0,
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic t_adv,
  output logic s1_red,
  output logic s1_yel,
  output logic s1_grn,
  output logic s2_red,
  output logic s2_yel,
  output logic s2_grn
);

  logic                  rst_q_n;
  logic [NUM_PHASES-1:0] phase_oh;
  lamp_t                 road1;
  lamp_t                 road2;

  tl_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  if (ONE_HOT) begin : g_oh
    tl_seq_onehot u_seq (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .t_adv    (t_adv),
      .phase_oh (phase_oh)
    );
  end else begin : g_enc
    tl_seq_enc u_seq (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .t_adv    (t_adv),
      .phase_oh (phase_oh)
    );
  end

  tl_lamp_dec u_dec (
    .phase_oh (phase_oh),
    .road1    (road1),
    .road2    (road2)
  );

  assign s1_red = road1.red;
  assign s1_yel = road1.yel;
  assign s1_grn = road1.grn;
  assign s2_red = road2.red;
  assign s2_yel = road2.yel;
  assign s2_grn = road2.grn;

endmodule

// File: rtl/tl_ring_chk.sv
module tl_ring_chk (
  input logic clk,
  input logic rst_n,
  input logic t_adv,
  input logic s1_red,
  input logic s1_yel,
  input logic s1_grn,
  input logic s2_red,
  input logic s2_yel,
  input logic s2_grn
);

  p_one_lamp_road1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({s1_red, s1_yel, s1_grn}) == 1);
  p_one_lamp_road2_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({s2_red, s2_yel, s2_grn}) == 1);
  p_no_conflict_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s1_red || s2_red);

  p_grn1_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_grn && !t_adv |=> s1_grn);
  p_grn1_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    s1_grn && t_adv |=> s1_yel && s2_red);
  p_yel1_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    s1_yel && t_adv |=> s1_yel);
  p_yel1_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    s1_yel && !t_adv |=> s1_red && s2_grn);
  p_grn2_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s2_grn && !t_adv |=> s2_grn);
  p_grn2_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s2_grn && t_adv |=> s2_yel && s1_red);
  p_yel2_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s2_yel && t_adv |=> s2_yel);
  p_yel2_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s2_yel && !t_adv |=> s1_grn && s2_red);

endmodule

bind tl_ring_ctrl tl_ring_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_q_n),
  .t_adv  (t_adv),
  .s1_red (s1_red),
  .s1_yel (s1_yel),
  .s1_grn (s1_grn),
  .s2_red (s2_red),
  .s2_yel (s2_yel),
  .s2_grn (s2_grn)
);

// File: tb/tl_ring_ctrl_tb.sv
`timescale 1ns/1ps
module tl_ring_ctrl_tb;

  // Lamp vector order: {s1_red, s1_yel, s1_grn, s2_red, s2_yel, s2_grn}
  localparam logic [5:0] L_G1R2 = 6'b001_100;
  localparam logic [5:0] L_Y1R2 = 6'b010_100;
  localparam logic [5:0] L_R1G2 = 6'b100_001;
  localparam logic [5:0] L_R1Y2 = 6'b100_010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic t_adv = 1'b0;
  logic e_r1, e_y1, e_g1, e_r2, e_y2, e_g2;
  logic o_r1, o_y1, o_g1, o_r2, o_y2, o_g2;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  tl_ring_ctrl #(.ONE_HOT(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .t_adv(t_adv),
    .s1_red(e_r1), .s1_yel(e_y1), .s1_grn(e_g1),
    .s2_red(e_r2), .s2_yel(e_y2), .s2_grn(e_g2)
  );

  tl_ring_ctrl #(.ONE_HOT(1'b1)) u_dut_oh (
    .clk(clk), .rst_n(rst_n), .t_adv(t_adv),
    .s1_red(o_r1), .s1_yel(o_y1), .s1_grn(o_g1),
    .s2_red(o_r2), .s2_yel(o_y2), .s2_grn(o_g2)
  );

  task automatic check(input logic [5:0] exp, input string tag);
    logic [5:0] enc = {e_r1, e_y1, e_g1, e_r2, e_y2, e_g2};
    logic [5:0] ohb = {o_r1, o_y1, o_g1, o_r2, o_y2, o_g2};
    checks++;
    if (enc !== exp) begin
      errors++;
      $display("FAIL %s: lamps got %b expected %b", tag, enc, exp);
    end
    checks++;
    if (ohb !== enc) begin
      errors++;
      $display("FAIL R8 %s: one-hot build %b expected encoded build %b", tag, ohb, enc);
    end
    checks++;
    if ($countones(enc[5:3]) != 1 || $countones(enc[2:0]) != 1 || !(enc[5] || enc[2])) begin
      errors++;
      $display("FAIL R7 %s: lamps got %b expected one lamp per road and a red", tag, enc);
    end
  endtask

  task automatic step(input logic lvl, input logic [5:0] exp, input string tag);
    @(negedge clk);
    t_adv = lvl;
    @(posedge clk);
    #1;
    check(exp, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    t_adv = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic walk_to_r1g2();
    step(1'b1, L_Y1R2, "R3 walk");
    step(1'b0, L_R1G2, "R4 walk");
  endtask

  task automatic test_reset_r1();
    @(negedge clk);
    rst_n = 1'b0;
    t_adv = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(L_G1R2, "R1 in reset with t high");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(L_G1R2, "R1 first edge after release");
    @(posedge clk); #1;
    check(L_G1R2, "R1 second edge after release");
    @(posedge clk); #1;
    check(L_Y1R2, "R1 third edge steps");
  endtask

  task automatic test_grn1_r2_r3();
    do_reset();
    for (int i = 0; i < 4; i++) step(1'b0, L_G1R2, "R2 hold");
    step(1'b1, L_Y1R2, "R3 step");
  endtask

  task automatic test_yel1_r4();
    do_reset();
    step(1'b1, L_Y1R2, "R3 enter");
    for (int i = 0; i < 4; i++) step(1'b1, L_Y1R2, "R4 hold");
    step(1'b0, L_R1G2, "R4 step");
  endtask

  task automatic test_grn2_r5();
    do_reset();
    walk_to_r1g2();
    for (int i = 0; i < 4; i++) step(1'b0, L_R1G2, "R5 hold");
    step(1'b1, L_R1Y2, "R5 step");
  endtask

  task automatic test_yel2_r6();
    do_reset();
    walk_to_r1g2();
    step(1'b1, L_R1Y2, "R5 enter");
    for (int i = 0; i < 4; i++) step(1'b1, L_R1Y2, "R6 hold");
    step(1'b0, L_G1R2, "R6 wrap");
  endtask

  task automatic test_laps();
    do_reset();
    for (int lap = 0; lap < 3; lap++) begin
      step(1'b1, L_Y1R2, "R3 fast lap");
      step(1'b0, L_R1G2, "R4 fast lap");
      step(1'b1, L_R1Y2, "R5 fast lap");
      step(1'b0, L_G1R2, "R6 fast lap");
    end
    for (int lap = 1; lap <= 3; lap++) begin
      for (int h = 0; h < lap; h++) step(1'b0, L_G1R2, "R2 uneven hold");
      step(1'b1, L_Y1R2, "R3 uneven");
      for (int h = 0; h < lap; h++) step(1'b1, L_Y1R2, "R4 uneven hold");
      step(1'b0, L_R1G2, "R4 uneven");
      for (int h = 0; h < lap + 1; h++) step(1'b0, L_R1G2, "R5 uneven hold");
      step(1'b1, L_R1Y2, "R5 uneven");
      for (int h = 0; h < lap + 1; h++) step(1'b1, L_R1Y2, "R6 uneven hold");
      step(1'b0, L_G1R2, "R6 uneven");
    end
  endtask

  task automatic test_async_r1();
    do_reset();
    walk_to_r1g2();
    step(1'b1, L_R1Y2, "R5 before reset");
    @(negedge clk);
    #0.5;
    rst_n = 1'b0;
    #0.5;
    check(L_G1R2, "R1 asynchronous assertion");
    @(negedge clk);
    rst_n = 1'b1;
    t_adv = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(L_G1R2, "R1 after release");
  endtask

  initial begin
    test_reset_r1();
    test_grn1_r2_r3();
    test_yel1_r4();
    test_grn2_r5();
    test_yel2_r6();
    test_laps();
    test_async_r1();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1..: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule